// File: doc/BRIEF.md
# Memory Barrier Hint Controller

This controller sits between a load/store issue stage and the memory system. It enforces memory barriers. A barrier request carries a 15-bit hint, and the controller stalls succeeding reads, succeeding writes, or both. The stall lasts until the earlier accesses named by the hint have drained. Two drain rules are available. In completion flavour the controller waits for the outstanding read and write counters to reach zero. In ordering flavour it waits only for the memory system to report that every earlier access of the named type has been accepted.

The low five hint bits are active-low selectors:

| Hint bit | Meaning when 0 | Meaning when 1 |
|---|---|---|
| 4 | Completion flavour | Ordering flavour |
| 3 | Barrier covers earlier reads | Earlier reads not covered |
| 2 | Barrier covers earlier writes | Earlier writes not covered |
| 1 | Succeeding reads are held | Succeeding reads not held |
| 0 | Succeeding writes are held | Succeeding writes not held |

Hint value 0x700 is a special code. It only keeps a read behind an earlier read to the same address, using an address-compare input.

A legacy strap turns every hint into a full completion barrier on all four directions.

A barrier is accepted only while the controller is idle. The controller raises a one-cycle done pulse in the cycle its wait condition holds, and it is idle again on the next cycle.

Top module: `mbar_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle: `block_rd`, `block_wr` and `bar_done` are all 0.
- R2: With legacy off and hint bit 4 = 0 (completion), the barrier finishes only in a cycle where every covered earlier-access counter is zero; the accepted inputs are ignored.
- R3: With legacy off and hint bit 4 = 1 (ordering), the barrier finishes in a cycle where every covered accepted input is 1, whatever the counter values.
- R4: Hint bit 3 = 0 puts earlier reads in the wait condition and bit 2 = 0 puts earlier writes in it; an earlier-access type whose bit is 1 never delays completion.
- R5: While a barrier waits and its condition is false, `block_rd` is 1 exactly when hint bit 1 = 0, and `block_wr` is 1 exactly when hint bit 0 = 0.
- R6: For hint 0x700 with legacy off, `block_wr` stays 0 and `block_rd` equals `succ_is_read & same_addr_hit`. The barrier finishes in the first waiting cycle where that product is 0.
- R7: With `legacy_mode` = 1 at acceptance, any hint (0x700 included) behaves as hint 0: completion flavour, all four directions covered.
- R8: `bar_done` is high for exactly one cycle, in the cycle the wait condition first holds. In that cycle both block outputs are 0, and in the next cycle all three outputs are 0.
- R9: A request is accepted only when idle, and it takes effect from the next cycle. A request presented while waiting, or in the done cycle, is ignored.
- R10: Hint bits 14:5 have no effect except when the whole hint equals 0x700.
- R11: A hint covering no earlier access type finishes in its first waiting cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Barrier request strobe |
| req_hint | input | 15 | Barrier hint code |
| legacy_mode | input | 1 | Strap: treat every hint as a full completion barrier |
| rd_outstanding | input | CNT_W | Count of earlier reads not yet complete |
| wr_outstanding | input | CNT_W | Count of earlier writes not yet complete |
| rd_accepted | input | 1 | All earlier reads have been accepted by memory |
| wr_accepted | input | 1 | All earlier writes have been accepted by memory |
| succ_is_read | input | 1 | The succeeding access presented is a read |
| same_addr_hit | input | 1 | That read matches the address of an outstanding read |
| block_rd | output | 1 | Hold succeeding reads |
| block_wr | output | 1 | Hold succeeding writes |
| bar_done | output | 1 | One-cycle barrier completion pulse |

## Verification
The hardest situation to reach is a waiting barrier whose condition flips while a new request is already on the input. This puts the done pulse, the ignored request and the next acceptance in three back-to-back cycles.

The stimulus holds `req_valid` high across a whole barrier and releases the counters one at a time, so that drain happens at a known cycle. A long random phase then mixes legacy, the same-address code and noise in the upper hint bits. That phase runs against a cycle model compared on every clock.

// File: rtl/mbar_pkg.sv
package mbar_pkg;

    localparam int HINT_W = 15;
    localparam logic [HINT_W-1:0] HINT_SAME_ADDR_RAR = 15'h700;

    // Decoded barrier configuration, held for the life of one barrier
    typedef struct packed {
        logic same_addr;   // same-address read-after-read only
        logic completion;  // 1: wait on counters, 0: wait on accept flags
        logic prev_rd;
        logic prev_wr;
        logic succ_rd;
        logic succ_wr;
    } bar_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } bar_state_e;

    function automatic bar_cfg_t decode_hint(input logic [HINT_W-1:0] hint,
                                             input logic legacy);
        bar_cfg_t c;
        if (legacy) begin
            c = '{same_addr: 1'b0, completion: 1'b1, prev_rd: 1'b1,
                  prev_wr: 1'b1, succ_rd: 1'b1, succ_wr: 1'b1};
        end else if (hint == HINT_SAME_ADDR_RAR) begin
            c = '{same_addr: 1'b1, completion: 1'b0, prev_rd: 1'b1,
                  prev_wr: 1'b0, succ_rd: 1'b1, succ_wr: 1'b0};
        end else begin
            // selector bits are active low
            c.same_addr  = 1'b0;
            c.completion = ~hint[4];
            c.prev_rd    = ~hint[3];
            c.prev_wr    = ~hint[2];
            c.succ_rd    = ~hint[1];
            c.succ_wr    = ~hint[0];
        end
        return c;
    endfunction

endpackage

// File: rtl/mbar_hint_decode.sv
module mbar_hint_decode
    import mbar_pkg::*;
(
    input  logic [HINT_W-1:0] hint,
    input  logic              legacy,
    output bar_cfg_t          cfg
);

    always_comb begin
        cfg = decode_hint(hint, legacy);
    end

endmodule

// File: rtl/mbar_drain_check.sv
module mbar_drain_check
    import mbar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  bar_cfg_t         cfg,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             rd_acked,
    input  logic             wr_acked,
    input  logic             succ_is_read,
    input  logic             addr_hit,
    output logic             drained,
    output logic             hold_rd,
    output logic             hold_wr
);

    localparam int NUM_LANES = 2;  // lane 0: reads, lane 1: writes

    logic [CNT_W-1:0]     lane_cnt [NUM_LANES];
    logic [NUM_LANES-1:0] lane_ack;
    logic [NUM_LANES-1:0] lane_sel;
    logic [NUM_LANES-1:0] lane_ok;
    logic                 all_ok;
    logic                 collision;

    assign lane_cnt[0] = rd_cnt;
    assign lane_cnt[1] = wr_cnt;
    assign lane_ack    = {wr_acked, rd_acked};
    assign lane_sel    = {cfg.prev_wr, cfg.prev_rd};

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            always_comb begin
                if (!lane_sel[i]) begin
                    lane_ok[i] = 1'b1;
                end else if (cfg.completion) begin
                    lane_ok[i] = (lane_cnt[i] == '0);
                end else begin
                    lane_ok[i] = lane_ack[i];
                end
            end
        end
    endgenerate

    assign all_ok    = &lane_ok;
    assign collision = succ_is_read & addr_hit;

    always_comb begin
        if (cfg.same_addr) begin
            drained = ~collision;
            hold_rd = collision;
            hold_wr = 1'b0;
        end else begin
            drained = all_ok;
            hold_rd = cfg.succ_rd & ~all_ok;
            hold_wr = cfg.succ_wr & ~all_ok;
        end
    end

endmodule

// File: rtl/mbar_ctrl.sv
module mbar_ctrl
    import mbar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [HINT_W-1:0] req_hint,
    input  logic              legacy_mode,
    input  logic [CNT_W-1:0]  rd_outstanding,
    input  logic [CNT_W-1:0]  wr_outstanding,
    input  logic              rd_accepted,
    input  logic              wr_accepted,
    input  logic              succ_is_read,
    input  logic              same_addr_hit,
    output logic              block_rd,
    output logic              block_wr,
    output logic              bar_done
);

    bar_state_e state_q;
    bar_cfg_t   cfg_new;
    bar_cfg_t   cfg_q;
    logic       drained;
    logic       hold_rd;
    logic       hold_wr;
    logic       in_wait;

    mbar_hint_decode u_decode (
        .hint   (req_hint),
        .legacy (legacy_mode),
        .cfg    (cfg_new)
    );

    mbar_drain_check #(.CNT_W(CNT_W)) u_drain (
        .cfg          (cfg_q),
        .rd_cnt       (rd_outstanding),
        .wr_cnt       (wr_outstanding),
        .rd_acked     (rd_accepted),
        .wr_acked     (wr_accepted),
        .succ_is_read (succ_is_read),
        .addr_hit     (same_addr_hit),
        .drained      (drained),
        .hold_rd      (hold_rd),
        .hold_wr      (hold_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_WAIT;
                        cfg_q   <= cfg_new;
                    end
                end
                ST_WAIT: begin
                    if (drained) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_wait  = (state_q == ST_WAIT);
    assign bar_done = in_wait & drained;
    assign block_rd = in_wait & hold_rd;
    assign block_wr = in_wait & hold_wr;

    // R8: the done pulse lasts one cycle and leaves everything released
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        bar_done |=> (!bar_done && !block_rd && !block_wr));

    // R8: no block is raised in the completion cycle
    a_r8_release_on_done: assert property (@(posedge clk) disable iff (rst)
        bar_done |-> (!block_rd && !block_wr));

    // R9: idle controller drives nothing
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!block_rd && !block_wr && !bar_done));

    // R2: a completion barrier on earlier reads ends only with no read outstanding
    a_r2_reads_drained: assert property (@(posedge clk) disable iff (rst)
        (bar_done && cfg_q.completion && cfg_q.prev_rd && !cfg_q.same_addr)
            |-> (rd_outstanding == '0));

    // R6: the same-address code never holds writes
    a_r6_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        (in_wait && cfg_q.same_addr) |-> !block_wr);

    // R7: legacy acceptance yields a full completion barrier
    a_r7_legacy_full: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req_valid && legacy_mode)
            |=> (cfg_q.completion && cfg_q.prev_rd && cfg_q.prev_wr &&
                 cfg_q.succ_rd && cfg_q.succ_wr && !cfg_q.same_addr));

endmodule

// File: tb/mbar_ctrl_bench.sv
module mbar_ctrl_bench;

    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [14:0]      req_hint = '0;
    logic             legacy_mode = 1'b0;
    logic [CNT_W-1:0] rd_outstanding = '0;
    logic [CNT_W-1:0] wr_outstanding = '0;
    logic             rd_accepted = 1'b1;
    logic             wr_accepted = 1'b1;
    logic             succ_is_read = 1'b0;
    logic             same_addr_hit = 1'b0;
    logic             block_rd;
    logic             block_wr;
    logic             bar_done;

    mbar_ctrl #(.CNT_W(CNT_W)) u_mbar_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_hint       (req_hint),
        .legacy_mode    (legacy_mode),
        .rd_outstanding (rd_outstanding),
        .wr_outstanding (wr_outstanding),
        .rd_accepted    (rd_accepted),
        .wr_accepted    (wr_accepted),
        .succ_is_read   (succ_is_read),
        .same_addr_hit  (same_addr_hit),
        .block_rd       (block_rd),
        .block_wr       (block_wr),
        .bar_done       (bar_done)
    );

    always #2 clk = ~clk;  // 250 MHz

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural reference state
    bit m_busy = 1'b0;
    bit m_same, m_cmp, m_pr, m_pw, m_sr, m_sw;
    bit e_brd, e_bwr, e_done;

    task automatic check_bit(input string what, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit ok_r, ok_w, hit;
            e_brd = 1'b0; e_bwr = 1'b0; e_done = 1'b0;
            if (m_busy && !rst) begin
                if (m_same) begin
                    hit    = succ_is_read && same_addr_hit;
                    e_brd  = hit;
                    e_done = !hit;
                end else begin
                    ok_r   = !m_pr || (m_cmp ? (rd_outstanding == 0) : rd_accepted);
                    ok_w   = !m_pw || (m_cmp ? (wr_outstanding == 0) : wr_accepted);
                    e_done = ok_r && ok_w;
                    e_brd  = m_sr && !e_done;
                    e_bwr  = m_sw && !e_done;
                end
            end
            check_bit("block_rd", block_rd, e_brd);
            check_bit("block_wr", block_wr, e_bwr);
            check_bit("bar_done", bar_done, e_done);
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0;
        end else if (!m_busy) begin
            if (req_valid) begin
                m_busy = 1'b1;
                if (legacy_mode) begin
                    m_same = 0; m_cmp = 1; m_pr = 1; m_pw = 1; m_sr = 1; m_sw = 1;
                end else if (req_hint == 15'h700) begin
                    m_same = 1; m_cmp = 0; m_pr = 1; m_pw = 0; m_sr = 1; m_sw = 0;
                end else begin
                    m_same = 0;
                    m_cmp  = !req_hint[4];
                    m_pr   = !req_hint[3];
                    m_pw   = !req_hint[2];
                    m_sr   = !req_hint[1];
                    m_sw   = !req_hint[0];
                end
            end
        end else if (e_done) begin
            m_busy = 1'b0;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic issue(input logic [14:0] h);
        req_valid = 1'b1;
        req_hint  = h;
        step();
        req_valid = 1'b0;
    endtask

    task automatic settle();
        rd_outstanding = '0; wr_outstanding = '0;
        rd_accepted = 1'b1; wr_accepted = 1'b1;
        same_addr_hit = 1'b0; succ_is_read = 1'b0;
        legacy_mode = 1'b0; req_valid = 1'b0;
        step(3);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        summary();
    end

    initial begin
        cur_req = "R1";
        step(3);
        rst = 1'b0;
        step(3);

        // R2: completion on all directions, accept flags must not matter
        cur_req = "R2";
        rd_outstanding = 3; wr_outstanding = 2;
        issue(15'h0000);
        step(2);
        rd_outstanding = 0; step(2);
        wr_outstanding = 1; step(1);
        wr_outstanding = 0; step(2);
        settle();

        // R3: ordering flavour waits on accept flags only
        cur_req = "R3";
        rd_outstanding = 5; wr_outstanding = 5;
        rd_accepted = 0; wr_accepted = 0;
        issue(15'h0010);
        step(2);
        rd_accepted = 1; step(2);
        wr_accepted = 1; step(2);
        settle();

        // R4: earlier reads not covered, wait on writes only
        cur_req = "R4";
        rd_outstanding = 7; wr_outstanding = 1;
        issue(15'h0008);
        step(2);
        wr_outstanding = 0; step(2);
        settle();
        rd_outstanding = 2; wr_outstanding = 4;
        issue(15'h0004);
        step(2);
        rd_outstanding = 0; step(2);
        settle();

        // R5: only covered succeeding types are held
        cur_req = "R5";
        rd_outstanding = 1; wr_outstanding = 1;
        issue(15'h0001);
        step(3);
        rd_outstanding = 0; wr_outstanding = 0; step(2);
        rd_outstanding = 1; wr_outstanding = 1;
        issue(15'h0002);
        step(3);
        settle();

        // R6: same-address read-after-read
        cur_req = "R6";
        rd_outstanding = 9; wr_outstanding = 9;
        succ_is_read = 1; same_addr_hit = 1;
        issue(15'h0700);
        step(2);
        succ_is_read = 0; step(1);
        succ_is_read = 1; same_addr_hit = 0; step(2);
        settle();

        // R7: legacy makes any hint a full completion barrier
        cur_req = "R7";
        legacy_mode = 1;
        rd_outstanding = 1; wr_outstanding = 0;
        succ_is_read = 1; same_addr_hit = 0;
        issue(15'h0700);
        step(2);
        rd_outstanding = 0; step(2);
        wr_outstanding = 2; rd_accepted = 1; wr_accepted = 1;
        issue(15'h001F);
        legacy_mode = 0;
        step(2);
        wr_outstanding = 0; step(2);
        settle();

        // R10: upper hint bits ignored outside the special code
        cur_req = "R10";
        rd_outstanding = 2; wr_outstanding = 0;
        issue(15'h7FE0);
        step(2);
        rd_outstanding = 0; step(2);
        rd_outstanding = 3; rd_accepted = 0;
        issue(15'h4011);
        step(2);
        rd_accepted = 1; step(2);
        settle();

        // R11: nothing earlier covered, done in first waiting cycle
        cur_req = "R11";
        rd_outstanding = 8; wr_outstanding = 8;
        issue(15'h000C);
        step(3);
        settle();

        // R9 and R8: request held high through wait and done cycles
        cur_req = "R9";
        rd_outstanding = 1; wr_outstanding = 1;
        req_valid = 1; req_hint = 15'h0000;
        step(3);
        req_hint = 15'h000F;
        rd_outstanding = 0; wr_outstanding = 0;
        step(1);
        req_hint = 15'h0000; rd_outstanding = 2;
        step(3);
        req_valid = 0; rd_outstanding = 0;
        step(3);
        settle();

        // R8: random mix against the cycle model
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            int sel;
            req_valid      = ($urandom_range(0, 3) == 0);
            sel            = $urandom_range(0, 9);
            case (sel)
                0: req_hint = 15'h0000;
                1: req_hint = 15'h0010;
                2: req_hint = 15'h0008;
                3: req_hint = 15'h0004;
                4: req_hint = 15'h0700;
                5: req_hint = 15'h001F;
                6: req_hint = 15'h0702;
                7: req_hint = 15'h0013;
                default: req_hint = 15'($urandom);
            endcase
            legacy_mode    = ($urandom_range(0, 7) == 0);
            rd_outstanding = ($urandom_range(0, 2) == 0) ? CNT_W'($urandom_range(1, 40)) : '0;
            wr_outstanding = ($urandom_range(0, 2) == 0) ? CNT_W'($urandom_range(1, 40)) : '0;
            rd_accepted    = ($urandom_range(0, 2) != 0);
            wr_accepted    = ($urandom_range(0, 2) != 0);
            succ_is_read   = $urandom_range(0, 1) == 1;
            same_addr_hit  = ($urandom_range(0, 2) == 0);
            step();
        end
        settle();

        summary();
    end

endmodule